// File: doc/BRIEF.md
# Receive Link Integrity Supervisor

This block watches a 10BASE-T receive path for signs of life and decides whether packet transmission may go ahead. Two one-cycle strobes come from the receive front end: one when a normal link pulse is qualified, one when a packet arrives. A third strobe marks each millisecond. Any receive event keeps the link healthy. A long silence makes the link fail, and packet transmission is then withheld. Link pulses keep being transmitted whatever this block decides, so the block has no control over them.

Once the link has failed it is regained in one of two ways. A single received packet is enough; its payload plays no part. The other way is a pair of link pulses whose spacing lies inside an acceptance window. A pulse that comes too soon or too late after the previous one restarts the pairing. One millisecond counter serves both purposes: it measures silence while the link is up and pulse spacing while it is down.

Top module: `link_integrity_mon`

## Requirements
- R1: After reset, link_ok and tx_pkt_en are both 0 (fail state) and no candidate pulse is held.
- R2: tx_pkt_en equals link_ok in every cycle; link pulse transmission is not gated by the block.
- R3: While link_ok is 1, the edge that samples the TIMEOUT_MS-th ms_tick with no receive event since the last restart clears link_ok.
- R4: While link_ok is 1, a cycle with nlp_rx or pkt_rx high restarts the silence count from zero. An ms_tick in that same cycle is not counted.
- R5: While link_ok is 0, pkt_rx high makes link_ok 1 on the next edge, whatever pulse history exists.
- R6: While link_ok is 0, a pulse that follows a held candidate pulse after G ms_ticks, with GAP_MIN_MS < G <= GAP_MAX_MS, makes link_ok 1 on the next edge. G counts the ticks in the cycles strictly between the two pulses.
- R7: While link_ok is 0, a pulse with no held candidate, or with G <= GAP_MIN_MS, or with G > GAP_MAX_MS, leaves link_ok 0 and becomes the new candidate.
- R8: Recovery restarts the silence count from zero, so link_ok falls exactly TIMEOUT_MS idle ticks after it rose.
- R9: A candidate pulse is never carried across a recovery. After the next loss, a lone pulse does not restore the link.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle strobe each millisecond |
| nlp_rx | input | 1 | One-cycle strobe per received normal link pulse |
| pkt_rx | input | 1 | One-cycle strobe per received packet |
| link_ok | output | 1 | Link is considered good |
| tx_pkt_en | output | 1 | Packet transmission allowed |

## Verification
The assertions assume that each input is a single-cycle strobe that is sampled only while reset is released, and that ms_tick is much slower than the clock, so that spacing is measured in whole ticks. The bench drives each strobe for exactly one cycle from a task. It uses a reduced configuration (timeout 8, window 3 to 5 ticks), so every spacing from 0 to 8 ticks and every idle length from 0 to 10 ticks can be swept. Only the boundary tests put a tick in the same cycle as an event, and they do it on purpose to exercise the counting rule.

// File: rtl/link_integrity_mon.sv
module link_integrity_mon #(
  parameter int TIMEOUT_MS = 75,
  parameter int GAP_MIN_MS = 6,
  parameter int GAP_MAX_MS = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic nlp_rx,
  input  logic pkt_rx,
  output logic link_ok,
  output logic tx_pkt_en
);
  localparam int TOP = (TIMEOUT_MS > GAP_MAX_MS + 1) ? TIMEOUT_MS : GAP_MAX_MS + 1;
  localparam int CW  = $clog2(TOP + 1);
  localparam logic [CW-1:0] LAST_IDLE = CW'(TIMEOUT_MS - 1);
  localparam logic [CW-1:0] WIN_LO    = CW'(GAP_MIN_MS);
  localparam logic [CW-1:0] WIN_HI    = CW'(GAP_MAX_MS);

  logic          ok_q, armed_q;
  logic [CW-1:0] cnt_q;

  wire in_win = armed_q && (cnt_q > WIN_LO) && (cnt_q <= WIN_HI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ok_q    <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (ok_q) begin
      if (pkt_rx || nlp_rx)
        cnt_q <= '0;
      else if (ms_tick) begin
        if (cnt_q == LAST_IDLE) begin
          ok_q  <= 1'b0;
          cnt_q <= '0;
        end else
          cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      if (pkt_rx || (nlp_rx && in_win)) begin
        ok_q    <= 1'b1;
        armed_q <= 1'b0;
        cnt_q   <= '0;
      end else if (nlp_rx) begin
        armed_q <= 1'b1;
        cnt_q   <= '0;
      end else if (ms_tick && armed_q && cnt_q <= WIN_HI)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign link_ok   = ok_q;
  assign tx_pkt_en = ok_q;
endmodule

module link_integrity_mon_chk #(
  parameter int TIMEOUT_MS = 75,
  parameter int GAP_MIN_MS = 6,
  parameter int GAP_MAX_MS = 50
) (
  input logic clk,
  input logic rst_n,
  input logic ms_tick,
  input logic nlp_rx,
  input logic pkt_rx,
  input logic link_ok,
  input logic tx_pkt_en
);
  int idle, gap;
  logic cand;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle <= 0; gap <= 0; cand <= 1'b0;
    end else begin
      if (!link_ok || pkt_rx || nlp_rx) idle <= 0;
      else if (ms_tick) idle <= idle + 1;
      if (link_ok) begin
        cand <= 1'b0; gap <= 0;
      end else if (nlp_rx) begin
        cand <= 1'b1; gap <= 0;
      end else if (ms_tick && gap <= GAP_MAX_MS) gap <= gap + 1;
    end
  end

  assert_tx_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pkt_en == link_ok);
  assert_idle_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    link_ok |-> idle < TIMEOUT_MS);
  assert_fall_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    link_ok && ms_tick && !nlp_rx && !pkt_rx && idle == TIMEOUT_MS - 1 |=> !link_ok);
  assert_activity_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    link_ok && (nlp_rx || pkt_rx) |=> link_ok);
  assert_pkt_restores_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_rx |=> link_ok);
  assert_pair_restores_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !link_ok && nlp_rx && cand && gap > GAP_MIN_MS && gap <= GAP_MAX_MS |=> link_ok);
  assert_bad_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !link_ok && nlp_rx && !pkt_rx && !(cand && gap > GAP_MIN_MS && gap <= GAP_MAX_MS)
    |=> !link_ok);
  assert_rise_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_ok) |-> $past(pkt_rx || nlp_rx));
endmodule

bind link_integrity_mon link_integrity_mon_chk #(
  .TIMEOUT_MS(TIMEOUT_MS), .GAP_MIN_MS(GAP_MIN_MS), .GAP_MAX_MS(GAP_MAX_MS)
) u_chk (.*);

// File: tb/tb_link_integrity_mon.sv
`timescale 1ns/1ps
module tb_link_integrity_mon;
  localparam int T = 8, LO = 2, HI = 5;

  logic clk = 1'b0, rst_n = 1'b0, ms_tick = 1'b0, nlp_rx = 1'b0, pkt_rx = 1'b0;
  logic link_ok, tx_pkt_en;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  link_integrity_mon #(.TIMEOUT_MS(T), .GAP_MIN_MS(LO), .GAP_MAX_MS(HI)) dut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .nlp_rx(nlp_rx), .pkt_rx(pkt_rx),
    .link_ok(link_ok), .tx_pkt_en(tx_pkt_en));

  task automatic step(input logic n, input logic p, input logic t);
    @(negedge clk);
    nlp_rx = n; pkt_rx = p; ms_tick = t;
    @(negedge clk);
    nlp_rx = 0; pkt_rx = 0; ms_tick = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 1);
  endtask

  task automatic chk(input string req, input logic exp);
    checks++;
    if (link_ok !== exp || tx_pkt_en !== exp) begin
      fails++;
      $display("FAIL %s: link_ok=%b tx_pkt_en=%b expected %b", req, link_ok, tx_pkt_en, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  initial begin
    do_reset();
    chk("R1 reset state", 1'b0);
    ticks(T + 2);
    chk("R1 idle after reset", 1'b0);

    for (int g = 0; g <= HI + 3; g++) begin
      do_reset();
      step(1, 0, 0);
      chk("R7 first pulse alone", 1'b0);
      ticks(g);
      step(1, 0, 0);
      chk($sformatf("R6/R7 gap %0d", g), (g > LO && g <= HI));
      if (!(g > LO && g <= HI)) begin
        ticks(LO + 1);
        step(1, 0, 0);
        chk($sformatf("R7 rejected pulse is new candidate, gap %0d", g), 1'b1);
      end
    end

    for (int k = 0; k <= T + 2; k++) begin
      do_reset();
      step(0, 1, 0);
      chk("R5 packet restores", 1'b1);
      ticks(k);
      chk($sformatf("R3/R8 idle %0d ticks", k), (k < T));
    end

    do_reset();
    step(0, 1, 0);
    ticks(T - 1);
    step(1, 0, 0);
    ticks(T - 1);
    chk("R4 pulse restarts count", 1'b1);
    step(0, 1, 1);
    ticks(T - 1);
    chk("R4 packet with tick restarts count", 1'b1);
    ticks(1);
    chk("R3 timeout after restart", 1'b0);

    do_reset();
    step(1, 0, 1);
    ticks(LO);
    step(1, 0, 0);
    chk("R6 tick coincident with pulse not counted", 1'b0);

    do_reset();
    step(1, 0, 0);
    ticks(HI + 2);
    step(0, 1, 0);
    chk("R5 packet with stale candidate", 1'b1);
    ticks(T);
    chk("R3 loss", 1'b0);
    step(1, 0, 0);
    chk("R9 lone pulse after loss", 1'b0);
    ticks(LO + 1);
    step(1, 0, 0);
    chk("R9 fresh pair after loss", 1'b1);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: done=0 expected 1");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule